// File: doc/BRIEF.md
# Programmable Chip-Select Bus Cycle Timer

This block runs single read and write accesses on an asynchronous parallel bus, such as a compact-flash or ATA port in PIO mode, for one chip-select region. The host programs the timing of each phase through a small register port. It then starts an access through a level request that it holds until a one-clock acknowledge. During each access the block drives the address, an active-low chip select, an active-low output enable or write enable, and the enable for the data bus. On reads it returns the word it captured from the bus.

Each phase has its own programmed count. The phases run in a fixed order: address setup with chip select still high, chip select to strobe, strobe active, an optional wait phase after IORDY, hold with chip select still low, and a pause with chip select high. A field value N gives N+1 ticks. A tick is 1, 2, 4 or 8 core clocks, chosen by a 2-bit code whose values do not rise with the multiplier. The prescaler restarts at the start of every phase. When wait mode is on, the strobe is held while IORDY is low.

Top module: `csb_cycle_timer`

## Requirements
- R1: During and right after reset, bus_cs_n, bus_oe_n and bus_we_n are 1, and bus_data_oe, ack and rd_data are 0. The region is disabled, and every timing field is 0.
- R2: The 2-bit multiplier code in control bits [3:2] selects how many core clocks make one tick: 0 gives 4, 1 gives 1, 2 gives 2, 3 gives 8. A phase whose field holds N lasts exactly (N+1) ticks, so bus_cs_n stays low for the sum of the chip-enable, strobe and hold phase lengths.
- R3: After a request is accepted, the phases follow each other in a fixed order. In address setup, bus_addr is valid and bus_cs_n is 1. From chip-enable delay through hold, bus_cs_n is 0. In the pause phase, bus_cs_n is 1 again. A strobe is never active while chip select is high.
- R4: Reads take their strobe width from register 2 and their hold from register 5. Writes take their strobe width from register 3 and their hold from register 6. A read asserts only bus_oe_n and a write asserts only bus_we_n, both active low.
- R5: With wait mode (control bit 1) set, the strobe phase does not end while bus_iordy is low. It ends at the first tick boundary where the base width has elapsed and bus_iordy is high. A wait phase of (register 4)+1 ticks then follows with the strobe still asserted. With wait mode clear, bus_iordy has no effect and there is no wait phase.
- R6: On a read, rd_data takes the value of bus_data_in at the clock edge where the output enable deasserts. It holds that value until the next read.
- R7: On a write, bus_data_oe is 1 and bus_data_out carries the request's write data from address setup through hold. bus_data_oe is 0 in pause and idle.
- R8: While the region enable (control bit 0) is clear, a request is not executed: no strobe or chip select toggles and no acknowledge is given.
- R9: ack is high for exactly one clock, in the clock after the pause phase ends. A request that is still present in that clock is not accepted until the next clock, so back-to-back requests are separated by one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index: 0 addr setup, 1 CE delay, 2 read strobe, 3 write strobe, 4 wait, 5 read hold, 6 write hold, 7 pause, 8 control |
| cfg_wdata | input | FW | Register write data |
| req | input | 1 | Access request, held until ack |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Last captured read word |
| bus_addr | output | AW | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output (read) enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_data_oe | output | 1 | Drive enable for the data bus |
| bus_data_out | output | DW | Data driven on writes |
| bus_data_in | input | DW | Data sampled on reads |
| bus_iordy | input | 1 | Device ready, stretches the strobe in wait mode |

## Verification
The bench builds the block with FW=4, AW=8 and DW=16. With FW=4 the largest field value, 15, is reachable, and under the ×8 code it gives a 128-clock phase that still fits a short run. It covers all four multiplier codes, and strobes stretched by IORDY stalls that both end inside and run past the base width. The 16-bit data width lets every captured read word differ from its neighbours.

// File: rtl/csbt_pkg.sv
package csbt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADR   = 3'd1,
    PH_CE    = 3'd2,
    PH_STRB  = 3'd3,
    PH_WAIT  = 3'd4,
    PH_HOLD  = 3'd5,
    PH_PAUSE = 3'd6
  } phase_e;

  // register index of each timing field
  localparam int unsigned F_ADR    = 0;
  localparam int unsigned F_CE     = 1;
  localparam int unsigned F_RSTRB  = 2;
  localparam int unsigned F_WSTRB  = 3;
  localparam int unsigned F_WAIT   = 4;
  localparam int unsigned F_RHOLD  = 5;
  localparam int unsigned F_WHOLD  = 6;
  localparam int unsigned F_PAUSE  = 7;
  localparam int unsigned N_FIELDS = 8;
  localparam int unsigned CTL_IDX  = 8;

  // multiplier code -> last prescaler count (ticks are lim+1 clocks)
  function automatic logic [2:0] tick_limit(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd3;
      2'd1:    return 3'd0;
      2'd2:    return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/csbt_regs.sv
module csbt_regs
  import csbt_pkg::*;
#(
  parameter int FW = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [3:0]                    cfg_addr,
  input  logic [FW-1:0]                 cfg_wdata,
  output logic                          en,
  output logic                          waitm,
  output logic [1:0]                    mult,
  output logic [N_FIELDS-1:0][FW-1:0]   tf
);

  logic [3:0] ctl_q;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) begin
        tf[g] <= '0;
      end else if (cfg_we && cfg_addr == 4'(g)) begin
        tf[g] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (cfg_we && cfg_addr == 4'(CTL_IDX)) begin
      ctl_q <= cfg_wdata[3:0];
    end
  end

  assign en    = ctl_q[0];
  assign waitm = ctl_q[1];
  assign mult  = ctl_q[3:2];

endmodule

// File: rtl/csbt_prescaler.sv
module csbt_prescaler
  import csbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       tick
);

  logic [2:0] pc;
  logic [2:0] lim;

  assign lim  = tick_limit(code);
  assign tick = (pc >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pc <= '0;
    end else if (pc >= lim) begin
      pc <= '0;
    end else begin
      pc <= pc + 3'd1;
    end
  end

endmodule

// File: rtl/csbt_sequencer.sv
module csbt_sequencer
  import csbt_pkg::*;
#(
  parameter int FW = 6,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        waitm,
  input  logic [1:0]                  mult,
  input  logic [N_FIELDS-1:0][FW-1:0] tf,
  input  logic                        req,
  input  logic                        req_wr,
  input  logic [AW-1:0]               req_addr,
  input  logic [DW-1:0]               req_wdata,
  output logic                        ack,
  output logic [DW-1:0]               rd_data,
  output logic [AW-1:0]               bus_addr,
  output logic                        bus_cs_n,
  output logic                        bus_oe_n,
  output logic                        bus_we_n,
  output logic                        bus_data_oe,
  output logic [DW-1:0]               bus_data_out,
  input  logic [DW-1:0]               bus_data_in,
  input  logic                        bus_iordy
);

  phase_e        st, st_n;
  logic          op_wr, op_wr_n;
  logic [FW-1:0] fcnt, ld;
  logic          tick, done, restart, accept;
  logic          strb_n, cs_n_ph, drive_n;

  csbt_prescaler u_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .code    (mult),
    .tick    (tick)
  );

  assign accept  = (st == PH_IDLE) && req && en && !ack;
  assign op_wr_n = accept ? req_wr : op_wr;
  assign done    = tick && (fcnt == '0);

  always_comb begin
    st_n = st;
    case (st)
      PH_IDLE:  if (accept) st_n = PH_ADR;
      PH_ADR:   if (done) st_n = PH_CE;
      PH_CE:    if (done) st_n = PH_STRB;
      PH_STRB:  if (done && (!waitm || bus_iordy)) st_n = waitm ? PH_WAIT : PH_HOLD;
      PH_WAIT:  if (done) st_n = PH_HOLD;
      PH_HOLD:  if (done) st_n = PH_PAUSE;
      PH_PAUSE: if (done) st_n = PH_IDLE;
      default:  st_n = PH_IDLE;
    endcase
  end

  assign restart = (st_n != st) || (st == PH_IDLE);

  always_comb begin
    case (st_n)
      PH_ADR:   ld = tf[F_ADR];
      PH_CE:    ld = tf[F_CE];
      PH_STRB:  ld = op_wr_n ? tf[F_WSTRB] : tf[F_RSTRB];
      PH_WAIT:  ld = tf[F_WAIT];
      PH_HOLD:  ld = op_wr_n ? tf[F_WHOLD] : tf[F_RHOLD];
      PH_PAUSE: ld = tf[F_PAUSE];
      default:  ld = '0;
    endcase
  end

  assign strb_n  = (st_n == PH_STRB) || (st_n == PH_WAIT);
  assign cs_n_ph = (st_n == PH_CE) || strb_n || (st_n == PH_HOLD);
  assign drive_n = op_wr_n && (st_n != PH_IDLE) && (st_n != PH_PAUSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= PH_IDLE;
      fcnt         <= '0;
      op_wr        <= 1'b0;
      ack          <= 1'b0;
      rd_data      <= '0;
      bus_addr     <= '0;
      bus_data_out <= '0;
      bus_cs_n     <= 1'b1;
      bus_oe_n     <= 1'b1;
      bus_we_n     <= 1'b1;
      bus_data_oe  <= 1'b0;
    end else begin
      st <= st_n;
      if (restart) begin
        fcnt <= ld;
      end else if (tick && fcnt != '0) begin
        fcnt <= fcnt - 1'b1;
      end
      if (accept) begin
        op_wr        <= req_wr;
        bus_addr     <= req_addr;
        bus_data_out <= req_wdata;
      end
      if (!op_wr && (st == PH_STRB || st == PH_WAIT) && st_n == PH_HOLD) begin
        rd_data <= bus_data_in;
      end
      ack         <= (st == PH_PAUSE) && (st_n == PH_IDLE);
      bus_cs_n    <= !cs_n_ph;
      bus_oe_n    <= !(strb_n && !op_wr_n);
      bus_we_n    <= !(strb_n && op_wr_n);
      bus_data_oe <= drive_n;
    end
  end

  // R9: acknowledge is a single-clock pulse
  p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R3: a strobe only appears inside chip select
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

  // R4: read and write strobes are never active together
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n));

  // R8: a disabled region stays idle
  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE && !en) |=> (st == PH_IDLE));

  // R5: low IORDY keeps the strobe phase in wait mode
  p_iordy_stretch_r5: assert property (@(posedge clk) disable iff (rst)
    (st == PH_STRB && waitm && !bus_iordy) |=> (st == PH_STRB));

  // R6: read data is the bus value at the output-enable release
  p_rd_capture_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe_n) |-> (rd_data == $past(bus_data_in)));

endmodule

// File: rtl/csb_cycle_timer.sv
module csb_cycle_timer
  import csbt_pkg::*;
#(
  parameter int FW = 6,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [FW-1:0] cfg_wdata,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cs_n,
  output logic          bus_oe_n,
  output logic          bus_we_n,
  output logic          bus_data_oe,
  output logic [DW-1:0] bus_data_out,
  input  logic [DW-1:0] bus_data_in,
  input  logic          bus_iordy
);

  logic                        en, waitm;
  logic [1:0]                  mult;
  logic [N_FIELDS-1:0][FW-1:0] tf;

  csbt_regs #(.FW(FW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .en        (en),
    .waitm     (waitm),
    .mult      (mult),
    .tf        (tf)
  );

  csbt_sequencer #(.FW(FW), .AW(AW), .DW(DW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .waitm        (waitm),
    .mult         (mult),
    .tf           (tf),
    .req          (req),
    .req_wr       (req_wr),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .ack          (ack),
    .rd_data      (rd_data),
    .bus_addr     (bus_addr),
    .bus_cs_n     (bus_cs_n),
    .bus_oe_n     (bus_oe_n),
    .bus_we_n     (bus_we_n),
    .bus_data_oe  (bus_data_oe),
    .bus_data_out (bus_data_out),
    .bus_data_in  (bus_data_in),
    .bus_iordy    (bus_iordy)
  );

endmodule

// File: tb/csb_cycle_timer_tb.sv
module csb_cycle_timer_tb;
  localparam int FW = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  localparam int P_IDLE = 0, P_ADR = 1, P_CE = 2, P_STB = 3, P_WT = 4, P_HLD = 5, P_PAU = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [FW-1:0] cfg_wdata = '0;
  logic          req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ack;
  logic [DW-1:0] rd_data, bus_data_out;
  logic [AW-1:0] bus_addr;
  logic          bus_cs_n, bus_oe_n, bus_we_n, bus_data_oe;
  logic [DW-1:0] bus_data_in = 16'hACE1;
  logic          bus_iordy = 1'b1;

  csb_cycle_timer #(.FW(FW), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rd_data(rd_data), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_data_oe(bus_data_oe),
    .bus_data_out(bus_data_out), .bus_data_in(bus_data_in), .bus_iordy(bus_iordy)
  );

  int n_chk = 0, n_fail = 0;
  bit chk_on = 1'b0, finished = 1'b0;
  int stall_left = 0;

  // configuration mirror
  int c_en = 0, c_wm = 0, c_code = 0;
  int f_adr = 0, f_ce = 0, f_rs = 0, f_ws = 0, f_wt = 0, f_rh = 0, f_wh = 0, f_pa = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mulv();
    case (c_code)
      0: return 4;
      1: return 1;
      2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic int plen(int ph, bit wr);
    case (ph)
      P_ADR: return (f_adr + 1) * mulv();
      P_CE:  return (f_ce + 1) * mulv();
      P_STB: return ((wr ? f_ws : f_rs) + 1) * mulv();
      P_WT:  return (f_wt + 1) * mulv();
      P_HLD: return ((wr ? f_wh : f_rh) + 1) * mulv();
      P_PAU: return (f_pa + 1) * mulv();
      default: return 1;
    endcase
  endfunction

  // behavioural reference
  int m_ph = P_IDLE, m_rem = 0;
  bit m_wr = 0, m_ack = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;

  always @(posedge clk) begin
    int old;
    bit ack_prev;
    if (rst) begin
      m_ph = P_IDLE; m_ack = 0; m_rd = '0; m_wr = 0;
    end else begin
      ack_prev = m_ack;
      m_ack = 0;
      if (m_ph == P_IDLE) begin
        if (req && c_en != 0 && !ack_prev) begin
          m_ph = P_ADR; m_wr = req_wr; m_addr = req_addr; m_wd = req_wdata;
          m_rem = plen(P_ADR, m_wr);
        end
      end else begin
        m_rem--;
        if (m_rem == 0) begin
          old = m_ph;
          case (m_ph)
            P_ADR: m_ph = P_CE;
            P_CE:  m_ph = P_STB;
            P_STB: begin
              if (c_wm != 0 && !bus_iordy) m_rem = mulv();
              else if (c_wm != 0) m_ph = P_WT;
              else begin m_ph = P_HLD; if (!m_wr) m_rd = bus_data_in; end
            end
            P_WT:  begin m_ph = P_HLD; if (!m_wr) m_rd = bus_data_in; end
            P_HLD: m_ph = P_PAU;
            default: begin m_ph = P_IDLE; m_ack = 1; end
          endcase
          if (m_ph != old && m_ph != P_IDLE) m_rem = plen(m_ph, m_wr);
        end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    bit stb, xcs, xdoe;
    if (chk_on && !rst) begin
      stb  = (m_ph == P_STB) || (m_ph == P_WT);
      xcs  = !((m_ph == P_CE) || stb || (m_ph == P_HLD));
      xdoe = m_wr && m_ph != P_IDLE && m_ph != P_PAU;
      chk("R3 bus_cs_n", int'(bus_cs_n), int'(xcs));
      chk("R4 bus_oe_n", int'(bus_oe_n), int'(!(stb && !m_wr)));
      chk("R4 bus_we_n", int'(bus_we_n), int'(!(stb && m_wr)));
      chk("R7 bus_data_oe", int'(bus_data_oe), int'(xdoe));
      chk("R9 ack", int'(ack), int'(m_ack));
      chk("R6 rd_data", int'(rd_data), int'(m_rd));
      if (m_ph != P_IDLE) chk("R3 bus_addr", int'(bus_addr), int'(m_addr));
      if (xdoe) chk("R7 bus_data_out", int'(bus_data_out), int'(m_wd));
    end
  end

  // read data source and IORDY stall generator
  always @(negedge clk) begin
    bus_data_in <= {bus_data_in[14:0], bus_data_in[15] ^ bus_data_in[13] ^ bus_data_in[12] ^ bus_data_in[10]};
    if ((!bus_oe_n || !bus_we_n) && stall_left > 0) begin
      bus_iordy = 1'b0;
      stall_left--;
    end else begin
      bus_iordy = 1'b1;
    end
  end

  task automatic wreg(int a, int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = FW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setcfg(int en, int wm, int code, int adr, int ce, int rs, int ws,
                        int wt, int rh, int wh, int pa);
    c_en = en; c_wm = wm; c_code = code;
    f_adr = adr; f_ce = ce; f_rs = rs; f_ws = ws; f_wt = wt; f_rh = rh; f_wh = wh; f_pa = pa;
    wreg(0, adr); wreg(1, ce); wreg(2, rs); wreg(3, ws);
    wreg(4, wt); wreg(5, rh); wreg(6, wh); wreg(7, pa);
    wreg(8, en | (wm << 1) | (code << 2));
  endtask

  task automatic access(bit wr, int a, int d, int stall);
    int cs_lo, st_lo, wd, ls, lw, m, k;
    cs_lo = 0; st_lo = 0; wd = 0;
    @(negedge clk);
    stall_left = stall;
    req = 1'b1; req_wr = wr; req_addr = AW'(a); req_wdata = DW'(d);
    forever begin
      @(negedge clk);
      if (!bus_cs_n) cs_lo++;
      if (!bus_oe_n || !bus_we_n) st_lo++;
      if (ack) break;
      wd++;
      if (wd > 5000) begin chk("R9 access timeout", 0, 1); break; end
    end
    req = 1'b0;
    stall_left = 0;
    m  = mulv();
    ls = plen(P_STB, wr);
    if (c_wm == 0) begin
      chk("R2 chip-select low length", cs_lo, plen(P_CE, wr) + ls + plen(P_HLD, wr));
      chk("R4/R5 strobe width, IORDY ignored", st_lo, ls);
    end else begin
      k = ((stall + 1 + m - 1) / m) * m;
      lw = plen(P_WT, wr);
      chk("R5 stretched strobe width", st_lo, ((k > ls) ? k : ls) + lw);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", int'(bus_cs_n), 1);
    chk("R1 oe_n in reset", int'(bus_oe_n), 1);
    chk("R1 we_n in reset", int'(bus_we_n), 1);
    chk("R1 data_oe in reset", int'(bus_data_oe), 0);
    chk("R1 ack in reset", int'(ack), 0);
    chk("R1 rd_data in reset", int'(rd_data), 0);
    rst = 1'b0;
    chk_on = 1'b1;
    // R8: reset leaves the region disabled, request ignored
    req = 1'b1; req_wr = 1'b1;
    begin
      int acks, lows;
      acks = 0; lows = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (ack) acks++;
        if (!bus_cs_n || !bus_oe_n || !bus_we_n) lows++;
      end
      chk("R8 no ack when disabled", acks, 0);
      chk("R8 no strobes when disabled", lows, 0);
    end
    req = 1'b0;

    // x1 multiplier
    setcfg(1, 0, 1, 1, 0, 3, 2, 0, 1, 0, 2);
    access(0, 8'h12, 0, 0);
    access(1, 8'h34, 16'hBEEF, 0);
    // x4 (code 0)
    setcfg(1, 0, 0, 0, 1, 2, 4, 0, 0, 2, 1);
    access(1, 8'h56, 16'h1234, 0);
    access(0, 8'h78, 0, 0);
    // x2 (code 2), IORDY low but wait mode off
    setcfg(1, 0, 2, 2, 1, 1, 3, 5, 2, 1, 0);
    access(0, 8'h9A, 0, 20);
    access(1, 8'hBC, 16'h5A5A, 20);
    // x8 (code 3) with saturated fields
    setcfg(1, 0, 3, 15, 0, 15, 1, 0, 15, 0, 15);
    access(0, 8'hDE, 0, 0);
    access(1, 8'hF0, 16'hC3C3, 0);
    // wait mode
    setcfg(1, 1, 1, 0, 1, 2, 2, 2, 1, 1, 0);
    access(0, 8'h01, 0, 10);
    access(1, 8'h02, 16'h7777, 0);
    setcfg(1, 1, 2, 1, 0, 3, 1, 0, 0, 2, 1);
    access(0, 8'h03, 0, 5);
    access(0, 8'h04, 0, 2);
    access(1, 8'h05, 16'h0F0F, 9);

    // R9: request held high across completion, two acks separated
    setcfg(1, 0, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    begin
      int acks, gap, last;
      acks = 0; gap = 0; last = -1;
      @(negedge clk);
      req = 1'b1; req_wr = 1'b0; req_addr = 8'hAA;
      for (int i = 0; i < 200 && acks < 2; i++) begin
        @(negedge clk);
        if (ack) begin
          if (last >= 0) gap = i - last;
          last = i; acks++;
        end
      end
      req = 1'b0;
      chk("R9 two back-to-back acks", acks, 2);
      chk("R9 ack spacing", gap, 1 + 1 + 1 + 2 + 1 + 1 + 1);
    end

    // R8: disabled again after use
    setcfg(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    req = 1'b1;
    begin
      int acks, lows;
      acks = 0; lows = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (ack) acks++;
        if (!bus_cs_n || !bus_oe_n || !bus_we_n || bus_data_oe) lows++;
      end
      chk("R8 disabled: no ack", acks, 0);
      chk("R8 disabled: bus quiet", lows, 0);
    end
    req = 1'b0;
    repeat (4) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule